// File: doc/BRIEF.md
# Lockstep Row-Parallel Integer Matrix Multiplier

This block forms the product C = A x B of two square unsigned integer matrices of order `N` using `N` processing lanes that run in lockstep. Lane `j` owns a private store that holds column `j` of A, column `j` of B and column `j` of C. A single row index therefore reaches a complete row of any of the three matrices across all lanes at once. A central sequencer steps through the rows `i` of C. For each row it first zeroes that row in every lane in one step. It then walks `k` from 0 to `N-1`. At each `k` it picks the scalar A[i][k] from lane `k` and broadcasts it, and every lane `j` adds A[i][k] * B[k][j] into its C[i][j]. The full product takes on the order of `N*N` steps rather than `N*N*N`.

Matrix words are written one at a time through a load port addressed by row and column. A one-cycle `start` launches a run. `busy` stays high while the sequencer works, and `done` pulses once when it finishes. The result is read back through a combinational read port, which is valid only while the block is not busy.

The sequencer has five states. `ST_IDLE` waits for `start`. `ST_CLEAR` zeroes the current row of C in every lane. `ST_MAC` performs one broadcast multiply-accumulate per cycle, with `k` running from 0 to `N-1`. `ST_ROWEND` closes a row. `ST_FINISH` raises `done`. The transitions are:
- IDLE to CLEAR on `start`, with the row and `k` set to 0.
- CLEAR to MAC.
- MAC to MAC while `k` is below `N-1`, incrementing `k`.
- MAC to ROWEND when `k` equals `N-1`.
- ROWEND to CLEAR for the next row when the row is below `N-1`.
- ROWEND to FINISH after the last row.
- FINISH to IDLE unconditionally.

Top module: `simd_matmul`

## Requirements
- R1: After reset, `busy` and `done` are 0 and `rd_data` reads 0 for every row/column address.
- R2: While not busy, `ld_en`=1 writes `ld_data` into element [`ld_row`][`ld_col`] of A when `ld_sel`=0, or of B when `ld_sel`=1.
- R3: After a run, C[i][j] read at `rd_row`=i, `rd_col`=j equals the exact unsigned sum over k of A[i][k]*B[k][j]. This holds without overflow even when every input is 2^DW-1, because the accumulator is 2*DW+clog2(N) bits wide.
- R4: A `start` seen while idle with `done` low raises `busy` in the next cycle. `busy` then stays high for exactly N*(N+2) consecutive cycles.
- R5: `done` is high for exactly one cycle: the first cycle after `busy` falls. `done` and `busy` are never high together.
- R6: While `busy` is high, `rd_data` is 0. While it is low, `rd_data` shows the addressed C element combinationally in the same cycle.
- R7: A `start` while busy is ignored. The run keeps its length, and no new run begins after `done`.
- R8: A load while busy is ignored. The result of the run and of a later run equals the product of the matrices loaded before the run.
- R9: Each run recomputes C from zero. Starting a second run without reloading gives the same C as the first run, not an accumulation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Write one matrix element |
| ld_sel | input | 1 | Target matrix: 0 = A, 1 = B |
| ld_row | input | IW | Row of the element written |
| ld_col | input | IW | Column of the element written, which selects the lane |
| ld_data | input | DW | Element value, unsigned |
| start | input | 1 | Launch a multiplication |
| busy | output | 1 | Sequencer running |
| done | output | 1 | One-cycle completion pulse |
| rd_row | input | IW | Row of C to read |
| rd_col | input | IW | Column of C to read |
| rd_data | output | AW | C element, or 0 while busy |

## Verification
A sequencer that skips a state, or a `k` or row counter that stops short or wraps wrongly, changes the length of the `busy` window. That fault shows the same cycle `busy` falls, through the cycle-exact N*(N+2) count and the `done` placement. A wrong broadcast lane or a wrong B row address corrupts specific C entries, and a missed row clear doubles the results of a repeated run. These faults stay hidden until the read-back after `done`. The bench covers them with identity, random, all-maximum and rerun matrices, so each lane and row position gives a distinct value. A lane that accepts writes while busy is caught by comparing C with the product of the matrices loaded before the run.

// File: rtl/simd_mm_pkg.sv
package simd_mm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_MAC,
        ST_ROWEND,
        ST_FINISH
    } mm_state_e;

endpackage

// File: rtl/simd_mm_ctrl.sv
module simd_mm_ctrl
    import simd_mm_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [IW-1:0] row_idx,
    output logic [IW-1:0] k_idx,
    output logic          clr_en,
    output logic          mac_en,
    output logic          busy,
    output logic          done
);

    localparam logic [IW-1:0] LAST = IW'(N - 1);

    mm_state_e     state_q, state_d;
    logic [IW-1:0] row_q, row_d;
    logic [IW-1:0] k_q, k_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            k_q     <= '0;
        end else begin
            state_q <= state_d;
            row_q   <= row_d;
            k_q     <= k_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        row_d   = row_q;
        k_d     = k_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_CLEAR;
                    row_d   = '0;
                    k_d     = '0;
                end
            end
            ST_CLEAR: begin
                state_d = ST_MAC;
                k_d     = '0;
            end
            ST_MAC: begin
                if (k_q == LAST) begin
                    state_d = ST_ROWEND;
                end else begin
                    k_d = k_q + 1'b1;
                end
            end
            ST_ROWEND: begin
                if (row_q == LAST) begin
                    state_d = ST_FINISH;
                end else begin
                    row_d   = row_q + 1'b1;
                    state_d = ST_CLEAR;
                end
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        clr_en = 1'b0;
        mac_en = 1'b0;
        busy   = 1'b0;
        done   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_CLEAR:  begin clr_en = 1'b1; busy = 1'b1; end
            ST_MAC:    begin mac_en = 1'b1; busy = 1'b1; end
            ST_ROWEND: busy = 1'b1;
            ST_FINISH: done = 1'b1;
        endcase
    end

    assign row_idx = row_q;
    assign k_idx   = k_q;

endmodule

// File: rtl/simd_mm_pick.sv
module simd_mm_pick #(
    parameter int N  = 4,
    parameter int W  = 8,
    parameter int IW = 2
) (
    input  logic [N*W-1:0] lanes,
    input  logic [IW-1:0]  sel,
    output logic [W-1:0]   out
);

    always_comb begin
        out = '0;
        for (int i = 0; i < N; i++) begin
            if (sel == IW'(i)) out = lanes[i*W +: W];
        end
    end

endmodule

// File: rtl/simd_mm_pe.sv
module simd_mm_pe #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int AW = 18,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_a,
    input  logic          wr_b,
    input  logic [IW-1:0] wr_row,
    input  logic [DW-1:0] wr_data,
    input  logic [IW-1:0] row_idx,
    input  logic [IW-1:0] k_idx,
    input  logic          clr_en,
    input  logic          mac_en,
    input  logic [DW-1:0] bcast,
    output logic [DW-1:0] a_out,
    input  logic [IW-1:0] c_rd_row,
    output logic [AW-1:0] c_rd_data
);

    // local column store of this lane
    logic [DW-1:0] a_col [N];
    logic [DW-1:0] b_col [N];
    logic [AW-1:0] c_col [N];

    logic [AW-1:0] prod;
    assign prod = AW'(bcast) * AW'(b_col[k_idx]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int r = 0; r < N; r++) begin
                a_col[r] <= '0;
                b_col[r] <= '0;
                c_col[r] <= '0;
            end
        end else begin
            if (wr_a) a_col[wr_row] <= wr_data;
            if (wr_b) b_col[wr_row] <= wr_data;
            if (clr_en) begin
                c_col[row_idx] <= '0;
            end else if (mac_en) begin
                c_col[row_idx] <= c_col[row_idx] + prod;
            end
        end
    end

    assign a_out     = a_col[row_idx];
    assign c_rd_data = c_col[c_rd_row];

endmodule

// File: rtl/simd_matmul.sv
module simd_matmul #(
    parameter int N  = 4,
    parameter int DW = 8,
    parameter int IW = (N > 1) ? $clog2(N) : 1,
    parameter int AW = 2 * DW + ((N > 1) ? $clog2(N) : 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic          ld_sel,
    input  logic [IW-1:0] ld_row,
    input  logic [IW-1:0] ld_col,
    input  logic [DW-1:0] ld_data,
    input  logic          start,
    output logic          busy,
    output logic          done,
    input  logic [IW-1:0] rd_row,
    input  logic [IW-1:0] rd_col,
    output logic [AW-1:0] rd_data
);

    logic [IW-1:0]   row_idx, k_idx;
    logic            clr_en, mac_en;
    logic [N*DW-1:0] a_lanes;
    logic [N*AW-1:0] c_lanes;
    logic [DW-1:0]   bcast;
    logic [AW-1:0]   c_pick;
    logic            ld_ok;

    simd_mm_ctrl #(.N(N), .IW(IW)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .row_idx (row_idx),
        .k_idx   (k_idx),
        .clr_en  (clr_en),
        .mac_en  (mac_en),
        .busy    (busy),
        .done    (done)
    );

    assign ld_ok = ld_en && !busy;

    for (genvar j = 0; j < N; j++) begin : g_lane
        logic wr_a_j, wr_b_j;
        assign wr_a_j = ld_ok && (ld_col == IW'(j)) && !ld_sel;
        assign wr_b_j = ld_ok && (ld_col == IW'(j)) &&  ld_sel;

        simd_mm_pe #(.N(N), .DW(DW), .AW(AW), .IW(IW)) u_pe (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_a      (wr_a_j),
            .wr_b      (wr_b_j),
            .wr_row    (ld_row),
            .wr_data   (ld_data),
            .row_idx   (row_idx),
            .k_idx     (k_idx),
            .clr_en    (clr_en),
            .mac_en    (mac_en),
            .bcast     (bcast),
            .a_out     (a_lanes[j*DW +: DW]),
            .c_rd_row  (rd_row),
            .c_rd_data (c_lanes[j*AW +: AW])
        );
    end

    // scalar A[i][k] comes from lane k
    simd_mm_pick #(.N(N), .W(DW), .IW(IW)) u_bcast (
        .lanes (a_lanes),
        .sel   (k_idx),
        .out   (bcast)
    );

    simd_mm_pick #(.N(N), .W(AW), .IW(IW)) u_rdsel (
        .lanes (c_lanes),
        .sel   (rd_col),
        .out   (c_pick)
    );

    assign rd_data = busy ? '0 : c_pick;

endmodule

// File: rtl/simd_matmul_chk.sv
module simd_matmul_chk #(
    parameter int N  = 4,
    parameter int AW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic [AW-1:0] rd_data
);

    localparam int RUNLEN = N * (N + 2);
    localparam int CW     = $clog2(RUNLEN + 1) + 1;

    logic [CW-1:0] busy_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    assert_start_launch_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> busy);

    assert_run_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == CW'(RUNLEN)));

    assert_done_after_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_not_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    assert_read_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_data == '0));

    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

endmodule

bind simd_matmul simd_matmul_chk #(.N(N), .AW(AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .rd_data (rd_data)
);

// File: tb/simd_matmul_bench.sv
`timescale 1ns/1ps
module simd_matmul_bench;

    localparam int N  = 4;
    localparam int DW = 8;
    localparam int IW = 2;
    localparam int AW = 2 * DW + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0, ld_sel = 1'b0, start = 1'b0;
    logic [IW-1:0] ld_row = '0, ld_col = '0, rd_row = '0, rd_col = '0;
    logic [DW-1:0] ld_data = '0;
    logic          busy, done;
    logic [AW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;

    longint ma [N][N];
    longint mb [N][N];

    always #10 clk = ~clk;

    simd_matmul #(.N(N), .DW(DW)) u_simd_matmul (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data), .start(start),
        .busy(busy), .done(done), .rd_row(rd_row), .rd_col(rd_col),
        .rd_data(rd_data)
    );

    task automatic chk(input string req, input string what, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic finish_sim();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    task automatic put(input bit sel, input int r, input int c, input longint v);
        @(negedge clk);
        ld_en = 1'b1; ld_sel = sel; ld_row = IW'(r); ld_col = IW'(c); ld_data = DW'(v);
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic load_all();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                put(1'b0, r, c, ma[r][c]);   // R2 A path
                put(1'b1, r, c, mb[r][c]);   // R2 B path
            end
    endtask

    // pulse start, time the busy window; inject=1 pokes start and a load mid-run
    task automatic run_mm(input bit inject);
        int cnt;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R4", "busy after start", busy, 1);
        cnt = 0;
        while (busy) begin
            cnt++;
            if (cnt == 2) chk("R6", "rd_data while busy", rd_data, 0);
            if (inject && cnt == 3) begin
                start = 1'b1;
                ld_en = 1'b1; ld_sel = 1'b0; ld_row = '0; ld_col = '0;
                ld_data = DW'(ma[0][0] ^ 8'hFF);
            end
            if (inject && cnt == 4) begin
                start = 1'b0; ld_en = 1'b0;
            end
            @(negedge clk);
        end
        chk("R4", "busy cycles", cnt, N * (N + 2));
        chk("R5", "done after busy", done, 1);
        @(negedge clk);
        chk("R5", "done one cycle", done, 0);
        chk("R7", "no restart", busy, 0);
    endtask

    task automatic check_c(input string req);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                longint e;
                e = 0;
                for (int k = 0; k < N; k++) e += ma[i][k] * mb[k][j];
                rd_row = IW'(i); rd_col = IW'(j);
                #2;
                chk(req, $sformatf("C[%0d][%0d]", i, j), rd_data, e);
            end
    endtask

    task automatic t_reset();
        chk("R1", "busy at reset", busy, 0);
        chk("R1", "done at reset", done, 0);
        for (int i = 0; i < N; i++)
            for (int j = 0; j < N; j++) begin
                rd_row = IW'(i); rd_col = IW'(j);
                #1;
                chk("R1", "C zero after reset", rd_data, 0);
            end
    endtask

    task automatic t_identity();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ma[r][c] = (r == c) ? 1 : 0;
                mb[r][c] = 16 * r + c + 3;
            end
        load_all();
        run_mm(1'b0);
        check_c("R3");
    endtask

    task automatic t_random(input int rounds);
        for (int t = 0; t < rounds; t++) begin
            for (int r = 0; r < N; r++)
                for (int c = 0; c < N; c++) begin
                    ma[r][c] = $urandom_range(0, 255);
                    mb[r][c] = $urandom_range(0, 255);
                end
            load_all();
            run_mm(1'b0);
            check_c("R3");
        end
    endtask

    task automatic t_maxval();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ma[r][c] = 255;
                mb[r][c] = 255;
            end
        load_all();
        run_mm(1'b0);
        check_c("R3");
    endtask

    task automatic t_busy_ignore();
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++) begin
                ma[r][c] = r * N + c + 1;
                mb[r][c] = 2 * c + r + 5;
            end
        load_all();
        run_mm(1'b1);          // R7 start and R8 load during busy
        check_c("R8");
        run_mm(1'b0);
        check_c("R8");
    endtask

    task automatic t_rerun();
        run_mm(1'b0);          // same matrices, no reload
        check_c("R9");
    endtask

    initial begin
        #5_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_sim();
    end

    initial begin
        #35;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_identity();
        t_random(4);
        t_maxval();
        t_busy_ignore();
        t_rerun();
        finish_sim();
    end

endmodule